// File: doc/BRIEF.md
# Four-Bit Function-Select ALU Slice

This block is a purely combinational arithmetic and logic slice. It takes two operands and a carry input and produces one result word. A three-bit function select picks one of eight operations: three arithmetic operations (sum, and subtraction in either direction), three bitwise logic operations, and two constant results. Subtraction is done as two's-complement addition, with the subtrahend inverted. The caller must drive the carry input high to get the true difference.

Wider datapaths are built by joining several slices to an external carry lookahead unit. The slice has no ripple carry-out. In its place it drives an active-low group generate and an active-low group propagate, computed from the two operands it actually adds. In the non-arithmetic modes both of these outputs sit at their inactive (high) level, so a slice in a logic mode never creates or passes a carry in a cascade. The operand width is a parameter with a default of 4. The select map is fixed.

Top module: `fourBitAluSlice`

## Requirements
- R1: With funcSel = 3'b000 (clear), funcOut is all zeros for every opA, opB and carryIn.
- R2: With funcSel = 3'b111 (preset), funcOut is all ones for every opA, opB and carryIn.
- R3: With funcSel = 3'b011, funcOut = (opA + opB + carryIn) mod 16.
- R4: With funcSel = 3'b010, funcOut = (opA + ~opB + carryIn) mod 16. When carryIn = 1 this is opA minus opB.
- R5: With funcSel = 3'b001, funcOut = (opB + ~opA + carryIn) mod 16. When carryIn = 1 this is opB minus opA.
- R6: With funcSel = 3'b100, funcOut is opA XOR opB. With 3'b101 it is opA OR opB. With 3'b110 it is opA AND opB.
- R7: In the logic and constant codes (000, 100, 101, 110, 111), carryIn has no effect on funcOut.
- R8: In the logic and constant codes, genN and propN are both 1.
- R9: In the arithmetic codes, take x as the first addend and y as the second addend (x=opB, y=~opA for 001; x=opA, y=~opB for 010; x=opA, y=opB for 011). Then genN is 0 exactly when x + y with no carry in overflows 4 bits. propN is 0 exactly when every bit of x|y is 1. The carry out of the full sum equals ~genN | (~propN & carryIn).
- R10: All outputs follow an input change with no clock edge, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 4 | First operand |
| opB | input | 4 | Second operand |
| funcSel | input | 3 | Function select code |
| carryIn | input | 1 | Carry into the least significant bit |
| funcOut | output | 4 | Function result |
| genN | output | 1 | Group carry generate, active low |
| propN | output | 1 | Group carry propagate, active low |

## Verification
Every select code is driven with all 256 operand pairs under both carry values, and each output is compared with a reference model written from the requirements. The sweep tells the two subtraction directions apart, and it separates XOR, OR and AND from each other and from the sums. The carry-toggling pass drives each vector with carryIn low and then high, which exposes any carry leaking into the logic and constant codes. The lookahead pass compares the carry out of the reference sum with genN and propN, so generate and propagate that have been swapped or not inverted are caught. It also covers the patterns where propagate is active without generate.

// File: rtl/aluSlicePkg.sv
package aluSlicePkg;

  typedef enum logic [2:0] {
    SEL_CLEAR   = 3'b000,
    SEL_BMINUSA = 3'b001,
    SEL_AMINUSB = 3'b010,
    SEL_ADD     = 3'b011,
    SEL_XOR     = 3'b100,
    SEL_OR      = 3'b101,
    SEL_AND     = 3'b110,
    SEL_PRESET  = 3'b111
  } selCode_e;

  typedef enum logic [1:0] {
    LOGIC_XOR  = 2'd0,
    LOGIC_OR   = 2'd1,
    LOGIC_AND  = 2'd2,
    LOGIC_NONE = 2'd3
  } logicOp_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic     arith;      // adder result and lookahead outputs are live
    logic     swapOps;    // first addend is opB, second comes from opA
    logic     invSecond;  // invert the second addend (subtraction)
    logicOp_e logicOp;    // bitwise function for the logic codes
    logic     forceZero;  // clear
    logic     forceOne;   // preset
  } aluStrobes_t;

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluSlicePkg::*;
(
  input  logic [2:0]  funcSel,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes = '{arith: 1'b0, swapOps: 1'b0, invSecond: 1'b0,
                logicOp: LOGIC_NONE, forceZero: 1'b0, forceOne: 1'b0};
    case (selCode_e'(funcSel))
      SEL_CLEAR:   strobes.forceZero = 1'b1;
      SEL_PRESET:  strobes.forceOne  = 1'b1;
      SEL_BMINUSA: begin
        strobes.arith     = 1'b1;
        strobes.swapOps   = 1'b1;
        strobes.invSecond = 1'b1;
      end
      SEL_AMINUSB: begin
        strobes.arith     = 1'b1;
        strobes.invSecond = 1'b1;
      end
      SEL_ADD:     strobes.arith   = 1'b1;
      SEL_XOR:     strobes.logicOp = LOGIC_XOR;
      SEL_OR:      strobes.logicOp = LOGIC_OR;
      SEL_AND:     strobes.logicOp = LOGIC_AND;
      default:     strobes.forceZero = 1'b1;
    endcase
  end

  // R1 R2: the clear and preset strobes are never active together
  always_comb begin
    if (!$isunknown(funcSel)) begin
      p_const_exclusive_r1: assert (!(strobes.forceZero && strobes.forceOne))
        else $error("clear and preset strobes both active");
    end
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluSlicePkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] funcOut,
  output logic             genN,
  output logic             propN
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] xOp, yRaw, yOp;
  logic [WIDTH:0]   sumExt;
  logic [WIDTH-1:0] bitGen, bitProp;
  logic [WIDTH-1:0] grpGen, grpProp;
  logic [WIDTH-1:0] logicRes;

  // Operand conditioning
  assign xOp  = strobes.swapOps ? opB : opA;
  assign yRaw = strobes.swapOps ? opA : opB;
  assign yOp  = strobes.invSecond ? ~yRaw : yRaw;

  // Adder
  assign sumExt = {1'b0, xOp} + {1'b0, yOp} + {{WIDTH{1'b0}}, carryIn};

  // Group generate and propagate
  assign bitGen  = xOp & yOp;
  assign bitProp = xOp | yOp;
  assign grpGen[0]  = bitGen[0];
  assign grpProp[0] = bitProp[0];

  for (genvar i = 1; i < WIDTH; i++) begin : g_lookahead
    assign grpGen[i]  = bitGen[i] | (bitProp[i] & grpGen[i-1]);
    assign grpProp[i] = bitProp[i] & grpProp[i-1];
  end

  // Bitwise logic unit
  always_comb begin
    case (strobes.logicOp)
      LOGIC_XOR: logicRes = opA ^ opB;
      LOGIC_OR:  logicRes = opA | opB;
      LOGIC_AND: logicRes = opA & opB;
      default:   logicRes = '0;
    endcase
  end

  // Result select
  always_comb begin
    if (strobes.forceZero)      funcOut = '0;
    else if (strobes.forceOne)  funcOut = '1;
    else if (strobes.arith)     funcOut = sumExt[WIDTH-1:0];
    else                        funcOut = logicRes;
  end

  assign genN  = strobes.arith ? ~grpGen[MSB]  : 1'b1;
  assign propN = strobes.arith ? ~grpProp[MSB] : 1'b1;

  // R9: the lookahead terms reproduce the adder's carry out
  always_comb begin
    if (!$isunknown({opA, opB, carryIn, strobes}) && strobes.arith) begin
      p_lookahead_carry_r9: assert (sumExt[WIDTH] == (grpGen[MSB] | (grpProp[MSB] & carryIn)))
        else $error("lookahead terms disagree with adder carry");
    end
  end

endmodule

// File: rtl/fourBitAluSlice.sv
module fourBitAluSlice
  import aluSlicePkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       funcSel,
  input  logic             carryIn,
  output logic [WIDTH-1:0] funcOut,
  output logic             genN,
  output logic             propN
);

  aluStrobes_t strobes;

  aluCtrl i_aluCtrl (
    .funcSel (funcSel),
    .strobes (strobes)
  );

  aluDatapath #(.WIDTH(WIDTH)) i_aluDatapath (
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .strobes (strobes),
    .funcOut (funcOut),
    .genN    (genN),
    .propN   (propN)
  );

  always_comb begin
    if (!$isunknown({opA, opB, funcSel, carryIn})) begin
      if (funcSel == 3'b000) begin
        p_clear_zero_r1: assert (funcOut == '0) else $error("clear result not zero");
      end
      if (funcSel == 3'b111) begin
        p_preset_ones_r2: assert (funcOut == '1) else $error("preset result not all ones");
      end
      if (funcSel == 3'b100) begin
        p_xor_result_r6: assert (funcOut == (opA ^ opB)) else $error("xor result wrong");
      end
      if (!funcSel[2] && funcSel != 3'b000) begin
        p_arith_decode_r9: assert (strobes.arith) else $error("arith code not decoded");
      end else begin
        p_idle_lookahead_r8: assert (genN && propN) else $error("lookahead active in non-arith mode");
      end
    end
  end

endmodule

// File: tb/test_fourBitAluSlice.sv
`timescale 1ns/1ps
module test_fourBitAluSlice;

  logic       clk = 1'b0;
  logic [3:0] opA = '0, opB = '0;
  logic [2:0] funcSel = '0;
  logic       carryIn = 1'b0;
  logic [3:0] funcOut;
  logic       genN, propN;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  fourBitAluSlice i_fourBitAluSlice (
    .opA(opA), .opB(opB), .funcSel(funcSel), .carryIn(carryIn),
    .funcOut(funcOut), .genN(genN), .propN(propN)
  );

  // Reference model written from the requirements
  function automatic logic [3:0] firstAdd(input logic [2:0] s, input logic [3:0] a, input logic [3:0] b);
    return (s == 3'b001) ? b : a;
  endfunction
  function automatic logic [3:0] secondAdd(input logic [2:0] s, input logic [3:0] a, input logic [3:0] b);
    case (s)
      3'b001:  return ~a;
      3'b010:  return ~b;
      default: return b;
    endcase
  endfunction
  function automatic logic [3:0] refF(input logic [2:0] s, input logic [3:0] a, input logic [3:0] b, input logic c);
    logic [4:0] t;
    t = {1'b0, firstAdd(s, a, b)} + {1'b0, secondAdd(s, a, b)} + {4'b0, c};
    case (s)
      3'b000:  return 4'h0;
      3'b111:  return 4'hF;
      3'b100:  return a ^ b;
      3'b101:  return a | b;
      3'b110:  return a & b;
      default: return t[3:0];
    endcase
  endfunction
  function automatic bit isArith(input logic [2:0] s);
    return (s == 3'b001) || (s == 3'b010) || (s == 3'b011);
  endfunction
  function automatic logic refGenN(input logic [2:0] s, input logic [3:0] a, input logic [3:0] b);
    logic [4:0] t;
    t = {1'b0, firstAdd(s, a, b)} + {1'b0, secondAdd(s, a, b)};
    return isArith(s) ? ~t[4] : 1'b1;
  endfunction
  function automatic logic refPropN(input logic [2:0] s, input logic [3:0] a, input logic [3:0] b);
    return isArith(s) ? ~(&(firstAdd(s, a, b) | secondAdd(s, a, b))) : 1'b1;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s sel=%b a=%h b=%h c=%b actual=%h expected=%h",
               req, funcSel, opA, opB, carryIn, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] s, input logic [3:0] a, input logic [3:0] b, input logic c);
    @(negedge clk);
    funcSel = s; opA = a; opB = b; carryIn = c;
    #1;
  endtask

  task automatic sweepCode(input string req, input logic [2:0] s);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++) begin
          apply(s, 4'(a), 4'(b), 1'(c));
          check(req, {4'b0, funcOut}, {4'b0, refF(s, 4'(a), 4'(b), 1'(c))});
        end
  endtask

  task automatic testReset;
    apply(3'b000, 4'h0, 4'h0, 1'b0);
    check("R1 initial", {2'b0, genN, propN, funcOut}, {2'b0, 1'b1, 1'b1, 4'h0});
  endtask

  task automatic testConstants;
    sweepCode("R1", 3'b000);
    sweepCode("R2", 3'b111);
  endtask

  task automatic testArith;
    sweepCode("R3", 3'b011);
    sweepCode("R4", 3'b010);
    sweepCode("R5", 3'b001);
    apply(3'b010, 4'h3, 4'h5, 1'b1);
    check("R4 3-5", {4'b0, funcOut}, 8'h0E);
    apply(3'b001, 4'h3, 4'h5, 1'b1);
    check("R5 5-3", {4'b0, funcOut}, 8'h02);
  endtask

  task automatic testLogic;
    sweepCode("R6 xor", 3'b100);
    sweepCode("R6 or",  3'b101);
    sweepCode("R6 and", 3'b110);
  endtask

  task automatic testCarryIgnored;
    logic [2:0] codes [5] = '{3'b000, 3'b100, 3'b101, 3'b110, 3'b111};
    for (int k = 0; k < 5; k++)
      for (int v = 0; v < 256; v += 7) begin
        logic [3:0] f0;
        apply(codes[k], 4'(v >> 4), 4'(v), 1'b0);
        f0 = funcOut;
        apply(codes[k], 4'(v >> 4), 4'(v), 1'b1);
        check("R7", {4'b0, funcOut}, {4'b0, f0});
      end
  endtask

  task automatic testLookahead;
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int c = 0; c < 2; c++) begin
            logic [2:0] sc;
            sc = 3'(s);
            apply(sc, 4'(a), 4'(b), 1'(c));
            if (isArith(sc)) begin
              logic [4:0] t;
              check("R9", {6'b0, genN, propN},
                    {6'b0, refGenN(sc, 4'(a), 4'(b)), refPropN(sc, 4'(a), 4'(b))});
              t = {1'b0, firstAdd(sc, 4'(a), 4'(b))} + {1'b0, secondAdd(sc, 4'(a), 4'(b))} + {4'b0, 1'(c)};
              check("R9 cascade", {7'b0, ~genN | (~propN & carryIn)}, {7'b0, t[4]});
            end else begin
              check("R8", {6'b0, genN, propN}, 8'h03);
            end
          end
  endtask

  task automatic testSettle;
    @(posedge clk);
    #0.5;
    funcSel = 3'b011; opA = 4'h9; opB = 4'h8; carryIn = 1'b1;
    #0.5;
    check("R10 sum", {2'b0, genN, propN, funcOut}, {2'b0, 1'b0, 1'b1, 4'h2});
    opB = 4'h6;
    #0.5;
    check("R10 propagate", {2'b0, genN, propN, funcOut}, {2'b0, 1'b1, 1'b0, 4'h0});
    funcSel = 3'b110;
    #0.5;
    check("R10 mode", {2'b0, genN, propN, funcOut}, {2'b0, 1'b1, 1'b1, 4'h0});
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    testReset();
    testConstants();
    testArith();
    testLogic();
    testCarryIgnored();
    testLookahead();
    testSettle();
    done = 1;
    summary();
  end

endmodule